// File: doc/BRIEF.md
# Bus Grant Latency Watchdog

This block times how long a bus master keeps a request open without receiving a grant. A latency count starts from zero each time a request is pending. A request is pending while the request line is high and the grant line is low. The count advances by one unit every two reference-clock cycles. When the count passes a programmable 16-bit limit, the block sets a sticky master-error flag.

An interrupt output follows that flag, gated by a mask input and a global interrupt-enable input. A limit of zero turns the timeout off completely.

The limit lives in the low half of a 32-bit register that software can reach through a small read/write port. The port works only while the controller reports that it is stopped or suspended. The upper 16 bits of the register read back as zero. After reset the limit is 0x0600, which is 153.6 µs at a 20 MHz reference.

Top module: `bus_grant_watchdog`

## Requirements
- R1: After reset the limit reads back as 0x00000600, and `err_o`, `irq_o` and `reg_rdata_o` are all zero.
- R2: While `stop_i` or `susp_i` is high, a `reg_wr_i` pulse stores `reg_wdata_i[15:0]` as the limit. A `reg_rd_i` pulse returns `{16'h0000, limit}` on `reg_rdata_o` one clock edge later.
- R3: A `reg_wr_i` pulse while both `stop_i` and `susp_i` are low leaves the limit unchanged.
- R4: A `reg_rd_i` pulse while both `stop_i` and `susp_i` are low returns zero on `reg_rdata_o`. With no read pulse, `reg_rdata_o` is zero.
- R5: With a nonzero limit L, consider `req_i` high and `gnt_i` low at consecutive rising edges, starting from an idle counter. `err_o` stays low through edge 2L+2 and is high after edge 2L+3. In other words, the count gains one unit per two clocks, and the error fires once the count exceeds L.
- R6: With a limit of zero, `err_o` never rises, however long the request stays pending.
- R7: A rising edge where `gnt_i` is high or `req_i` is low restarts the timing of the next request from zero.
- R8: `err_o` is sticky. It stays high until an `err_clr_i` pulse at an edge where no timeout is active. A timeout in the same edge as a clear keeps the flag set.
- R9: `irq_o` equals `err_o AND NOT err_mask_i AND irq_en_i`, with the inputs taken at the same edge that updates `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus request from the master |
| gnt_i | input | 1 | Bus grant from the arbiter |
| stop_i | input | 1 | Controller stopped |
| susp_i | input | 1 | Controller suspended |
| reg_wr_i | input | 1 | Limit register write strobe |
| reg_rd_i | input | 1 | Limit register read strobe |
| reg_wdata_i | input | 32 | Write data, low 16 bits hold the limit |
| reg_rdata_o | output | 32 | Registered read data |
| err_clr_i | input | 1 | Write-one-to-clear pulse for the error flag |
| err_mask_i | input | 1 | Master-error interrupt mask, high suppresses |
| irq_en_i | input | 1 | Global interrupt enable |
| err_o | output | 1 | Sticky master-error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and settles well before each rising edge. They also assume `rst` is held high for at least one edge before checking begins. The bench changes inputs only a fixed delay after a rising edge and keeps the reset asserted for several cycles. Grant and request are treated as levels with no handshake ordering, so the bench drives every combination, including a grant with no request, without breaking any assumption.

// File: rtl/bgw_pkg.sv
package bgw_pkg;
  localparam int unsigned LIMIT_W       = 16;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned PRESCALE      = 2;
  localparam logic [LIMIT_W-1:0] RST_LIMIT = 16'h0600;
endpackage

// File: rtl/bgw_limit_reg.sv
module bgw_limit_reg #(
  parameter int unsigned LIMIT_W = 16,
  parameter int unsigned REG_W   = 32,
  parameter logic [LIMIT_W-1:0] RST_LIMIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               access_ok_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [LIMIT_W-1:0] wdata_i,
  output logic [LIMIT_W-1:0] limit_o,
  output logic [REG_W-1:0]   rdata_o
);
  localparam int unsigned PAD_W = REG_W - LIMIT_W;

  logic [LIMIT_W-1:0] limit_q;
  logic [REG_W-1:0]   rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= RST_LIMIT;
      rdata_q <= '0;
    end else begin
      if (wr_i && access_ok_i) limit_q <= wdata_i;
      if (rd_i && access_ok_i) rdata_q <= {{PAD_W{1'b0}}, limit_q};
      else                     rdata_q <= '0;
    end
  end

  assign limit_o = limit_q;
  assign rdata_o = rdata_q;

  p_locked_r3: assert property (@(posedge clk) disable iff (rst)
    !access_ok_i |=> $stable(limit_q))
    else $error("limit changed while locked");

  p_rd_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_i && access_ok_i) |=> (rdata_q == '0))
    else $error("read data without permitted read");

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rdata_q[REG_W-1:LIMIT_W] == '0)
    else $error("upper read bits nonzero");
endmodule

// File: rtl/bgw_latency_timer.sv
module bgw_latency_timer #(
  parameter int unsigned LIMIT_W  = 16,
  parameter int unsigned PRESCALE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pending_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               tout_o
);
  localparam int unsigned CNT_W = LIMIT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             tick;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int unsigned PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || !pending_i)       pre_q <= '0;
        else if (pre_q == PRE_LAST)  pre_q <= '0;
        else                         pre_q <= pre_q + 1'b1;
      end
      assign tick = pending_i && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick = pending_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !pending_i)           cnt_q <= '0;
    else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign tout_o = pending_i && (limit_i != '0) && (cnt_q > {1'b0, limit_i});

  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    !pending_i |=> (cnt_q == '0))
    else $error("count not restarted");

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    pending_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)))
    else $error("count jumped");
endmodule

// File: rtl/bgw_err_flag.sv
module bgw_err_flag (
  input  logic clk,
  input  logic rst,
  input  logic tout_i,
  input  logic clr_i,
  input  logic mask_i,
  input  logic ien_i,
  output logic err_o,
  output logic irq_o
);
  logic err_q, irq_q, err_d;

  assign err_d = tout_i | (err_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      err_q <= err_d;
      irq_q <= err_d & ~mask_i & ien_i;
    end
  end

  assign err_o = err_q;
  assign irq_o = irq_q;

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_i) |=> err_q)
    else $error("error flag dropped without clear");

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    tout_i |=> err_q)
    else $error("timeout did not set flag");

  p_irq_err_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> err_q)
    else $error("irq without error");

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_i || !ien_i) |=> !irq_q)
    else $error("irq despite mask or disable");
endmodule

// File: rtl/bus_grant_watchdog.sv
module bus_grant_watchdog
  import bgw_pkg::*;
#(
  parameter int unsigned LW   = LIMIT_W,
  parameter int unsigned RW   = REG_W,
  parameter int unsigned PRE  = PRESCALE,
  parameter logic [LW-1:0] RST_LIM = RST_LIMIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          gnt_i,
  input  logic          stop_i,
  input  logic          susp_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [RW-1:0] reg_wdata_i,
  output logic [RW-1:0] reg_rdata_o,
  input  logic          err_clr_i,
  input  logic          err_mask_i,
  input  logic          irq_en_i,
  output logic          err_o,
  output logic          irq_o
);
  logic          pending;
  logic          access_ok;
  logic          tout;
  logic [LW-1:0] limit;
  logic          wdata_hi_unused;

  assign pending         = req_i & ~gnt_i;
  assign access_ok       = stop_i | susp_i;
  assign wdata_hi_unused = ^reg_wdata_i[RW-1:LW];

  bgw_limit_reg #(
    .LIMIT_W(LW), .REG_W(RW), .RST_LIMIT(RST_LIM)
  ) u_limit (
    .clk(clk), .rst(rst), .access_ok_i(access_ok),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .wdata_i(reg_wdata_i[LW-1:0]),
    .limit_o(limit), .rdata_o(reg_rdata_o)
  );

  bgw_latency_timer #(
    .LIMIT_W(LW), .PRESCALE(PRE)
  ) u_timer (
    .clk(clk), .rst(rst), .pending_i(pending),
    .limit_i(limit), .tout_o(tout)
  );

  bgw_err_flag u_err (
    .clk(clk), .rst(rst), .tout_i(tout), .clr_i(err_clr_i),
    .mask_i(err_mask_i), .ien_i(irq_en_i),
    .err_o(err_o), .irq_o(irq_o)
  );

  p_zero_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (limit == '0 && !err_o) |=> !err_o)
    else $error("error raised with zero limit");

  p_idle_no_tout_r7: assert property (@(posedge clk) disable iff (rst)
    !pending |-> !tout)
    else $error("timeout while idle");
endmodule

// File: tb/tb_bus_grant_watchdog.sv
`timescale 1ns/1ps
module tb_bus_grant_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 0, gnt = 0, stop = 0, susp = 0, wr = 0, rd = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        clr = 0, mask = 0, ien = 1;
  logic        err, irq;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  bus_grant_watchdog dut (
    .clk(clk), .rst(rst), .req_i(req), .gnt_i(gnt), .stop_i(stop),
    .susp_i(susp), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .err_clr_i(clr), .err_mask_i(mask),
    .irq_en_i(ien), .err_o(err), .irq_o(irq)
  );

  // {limit[16], pending edges[16], expected err[1]}
  localparam logic [32:0] VEC [0:7] = '{
    {16'd3,  16'd8,  1'b0}, {16'd3,  16'd9,  1'b1},
    {16'd1,  16'd4,  1'b0}, {16'd1,  16'd5,  1'b1},
    {16'd10, 16'd22, 1'b0}, {16'd10, 16'd23, 1'b1},
    {16'd0,  16'd40, 1'b0}, {16'd0,  16'd300, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_lim(input logic [31:0] v, input logic s, input logic p);
    stop = s; susp = p; wr = 1; wdata = v; step();
    wr = 0; stop = 0; susp = 0;
  endtask

  task automatic read_lim(input logic s, input logic p, output logic [31:0] v);
    stop = s; susp = p; rd = 1; step();
    v = rdata; rd = 0; stop = 0; susp = 0;
  endtask

  task automatic idle_clear();
    req = 0; gnt = 0; clr = 1; step(); clr = 0;
  endtask

  task automatic pend(input int n);
    req = 1; gnt = 0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1; rst = 0;
    // R1 reset state
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    read_lim(1, 0, v);
    chk("R1 default limit", v, 32'h0000_0600);

    // vector table: R5 timing, R6 zero limit, R9 irq follows err
    foreach (VEC[i]) begin
      write_lim({16'hA5A5, VEC[i][32:17]}, 1, 0);
      idle_clear();
      pend(int'(VEC[i][16:1]));
      chk(VEC[i][32:17] == 0 ? "R6 zero limit err" : "R5 err timing",
          {31'd0, err}, {31'd0, VEC[i][0]});
      chk("R9 irq", {31'd0, irq}, {31'd0, VEC[i][0]});
      idle_clear();
    end

    // R2 write with susp, upper bits read as zero
    write_lim(32'h1234_5678, 0, 1);
    read_lim(0, 1, v);
    chk("R2 readback", v, 32'h0000_5678);
    // R3 locked write ignored
    write_lim(32'h0000_0BAD, 0, 0);
    read_lim(1, 0, v);
    chk("R3 locked write", v, 32'h0000_5678);
    // R4 locked read returns zero
    read_lim(0, 0, v);
    chk("R4 locked read", v, 32'd0);

    // R7 restart on grant and on request drop
    write_lim(32'd3, 1, 0);
    idle_clear();
    pend(7); gnt = 1; step(); gnt = 0;
    pend(8);
    chk("R7 after grant restart", {31'd0, err}, 32'd0);
    pend(1);
    chk("R7 after grant fires", {31'd0, err}, 32'd1);
    idle_clear();
    pend(7); req = 0; step();
    pend(8);
    chk("R7 after req drop", {31'd0, err}, 32'd0);
    idle_clear();

    // R8 sticky, clear, set wins
    pend(12);
    req = 0; step(); step(); step();
    chk("R8 sticky", {31'd0, err}, 32'd1);
    pend(12); clr = 1; step(); clr = 0;
    chk("R8 set wins over clear", {31'd0, err}, 32'd1);
    req = 0; clr = 1; step(); clr = 0;
    chk("R8 cleared", {31'd0, err}, 32'd0);

    // R9 mask and enable
    mask = 1; pend(12);
    chk("R9 masked err", {31'd0, err}, 32'd1);
    chk("R9 masked irq", {31'd0, irq}, 32'd0);
    req = 0; mask = 0; step();
    chk("R9 unmasked irq", {31'd0, irq}, 32'd1);
    ien = 0; step();
    chk("R9 disabled irq", {31'd0, irq}, 32'd0);
    ien = 1; idle_clear();
    chk("R8 clear drops irq", {31'd0, irq}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule